// File: doc/BRIEF.md
# Paged Three-Wire Register Bus Master

This block turns logical register accesses into bit-level traffic on a three-wire serial register bus: a direction line (high while the master transmits), a bus clock, and one bidirectional data line, presented here as an output value, an output enable and an input value for an external pad. A client hands over one request at a time on a ready/valid port. Each request is a write or a read of a 5-bit logical address. Reads return their byte with a one-cycle done strobe. Writes also end with that strobe.

The logical space spans two banks. Addresses 0x00..0x0F are bank 1 and 0x10..0x1F are bank 2. The block sends the low four bits as the physical address. It tracks which bank the device currently has selected. When a request targets the other bank, it first issues a complete write of the bank number to the bank-select register at physical address 0x01. Three registers have their write data rewritten before transmission. A power-enable input lets the client keep the bus silent while the device is unpowered.

Top module: `tw_bus_master`

## Requirements
- R1: Every byte is shifted least-significant bit first. For each bit the bus clock is held low for exactly HALF_CYC system clocks, with the data line set during that low phase and held unchanged through it. The clock then rises and stays high for HALF_CYC clocks.
- R2: A write is sent as one transmit window (direction high) carrying 16 bits. The first byte is the data and the second byte is the physical address.
- R3: A transmit window opens with the direction line high and the data driver enabled, exactly HALF_CYC clocks before the first clock fall. It closes by releasing the driver and lowering direction together, followed by a HALF_CYC-clock wait. The data driver is never enabled while direction is low.
- R4: A read sends an 8-bit transmit window holding only the physical address. It then gives 8 clock pulses with direction low and the driver released, sampling the data input at the end of each low phase. It assembles the byte LSB first and presents it on rd_data while done is high.
- R5: Logical addresses with bit 4 set belong to bank 2 (bank value 2). Others belong to bank 1 (bank value 1). The physical address sent is the logical address with bit 4 cleared.
- R6: When the tracked bank differs from the target bank, a 16-bit write window carrying data = bank value and address = 0x01 precedes the target access. When the banks match, no such window is sent.
- R7: After reset the tracked bank is invalid, so the first powered access always begins with a bank-select window.
- R8: A write to logical address 0x03 transmits 255 minus the data.
- R9: A write to logical address 0x09 transmits 255 minus the data when the data is below 64. Otherwise it transmits 191 minus the data, modulo 256.
- R10: A write to logical address 0x12 transmits the data with bits 4, 1 and 0 forced to 1.
- R11: Writes to all other logical addresses transmit the data unchanged.
- R12: While pwr_en is low, an accepted request produces done on the next cycle with rd_data equal to zero. It produces no bus clock or direction activity and leaves the tracked bank unchanged.
- R13: req_ready is high only while the block is idle, and a request is taken only when req_valid and req_ready are both high. done is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Device powered; when low requests complete without bus traffic |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Logical register address |
| req_wdata | input | 8 | Logical write data |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Read result, valid with done (zero for writes and unpowered reads) |
| bus_dir | output | 1 | Direction line, high while the master transmits |
| bus_clk | output | 1 | Bus clock, idles high |
| dat_out | output | 1 | Value driven on the data line |
| dat_oe | output | 1 | Data line driver enable |
| dat_in | input | 1 | Value read from the data line |

## Verification
On every cycle the assertions guard these properties: the data line stays steady across each clock-low phase, the driver is enabled only under a high direction line, and the shifter is never restarted mid-byte. They also check that a committed bank matches on the next cycle, that an unpowered request finishes at once with zero, and that done and ready keep their one-cycle handshake. Only the bench's scenarios can show the byte order and content of each window, the bank-select insertion and its suppression across a mixed sequence of banks, the three data rewrites at their boundary values, and the LSB-first assembly of read data. It checks these with a bus-side model that records every window and feeds read bits.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int LOG_AW  = 5;
  localparam int BYTE_W  = 8;
  localparam logic [BYTE_W-1:0] SEL_ADDR = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BEGIN,
    S_SEL_D,
    S_SEL_A,
    S_SEL_E,
    S_TGT0,
    S_TGT1,
    S_END,
    S_RX,
    S_DONE
  } tw_state_e;

  // Bank number (1 or 2) owning a logical address
  function automatic logic [1:0] bank_of(input logic [LOG_AW-1:0] a);
    return a[LOG_AW-1] ? 2'd2 : 2'd1;
  endfunction

  // Physical address sent on the wire
  function automatic logic [BYTE_W-1:0] phys_of(input logic [LOG_AW-1:0] a);
    return {{(BYTE_W-LOG_AW+1){1'b0}}, a[LOG_AW-2:0]};
  endfunction

  // Per-register rewrite of write data
  function automatic logic [BYTE_W-1:0] remap_wdata(input logic [LOG_AW-1:0] a,
                                                    input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] r;
    case (a)
      5'h03:   r = 8'd255 - d;
      5'h09:   r = (d < 8'd64) ? (8'd255 - d) : (8'd191 - d);
      5'h12:   r = d | 8'h13;
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tw_bank_tracker.sv
module tw_bank_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tgt_bank,
  input  logic       commit,
  output logic       match
);

  logic [1:0] cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= 2'd0;   // invalid: forces a select first
    else if (commit) cur_q <= tgt_bank;
  end

  assign match = (cur_q == tgt_bank);

  // R7: tracked bank is never a legal value until the first commit
  a_r7_invalid_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != 2'd0) |-> ($past(commit) || $stable(cur_q)));

endmodule

// File: rtl/tw_byte_shifter.sv
module tw_byte_shifter #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rx_mode,
  input  logic [7:0] tx_byte,
  input  logic       din,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       bus_clk,
  output logic       dout
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic          active, low_ph, rx_m;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          ph_end;

  assign ph_end = active && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      low_ph <= 1'b0;
      rx_m   <= 1'b0;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
    end else if (start) begin
      active <= 1'b1;
      low_ph <= 1'b1;
      rx_m   <= rx_mode;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= tx_byte;
    end else if (active) begin
      if (ph_end) begin
        cnt <= '0;
        if (low_ph) begin
          low_ph <= 1'b0;
          if (rx_m) sh <= {din, sh[7:1]};
        end else if (bidx == 3'd7) begin
          active <= 1'b0;
        end else begin
          bidx   <= bidx + 3'd1;
          low_ph <= 1'b1;
          if (!rx_m) sh <= {1'b0, sh[7:1]};
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign done    = ph_end && !low_ph && (bidx == 3'd7);
  assign rx_byte = sh;
  assign bus_clk = !(active && low_ph);
  assign dout    = sh[0];

  // R1: data line does not move while the clock stays low
  a_r1_data_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_clk && $past(!bus_clk)) |-> $stable(dout));

  // R1: a new byte starts only when idle or at the end of the last bit
  a_r1_no_restart_midbyte: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active || done));

endmodule

// File: rtl/tw_sequencer.sv
module tw_sequencer
  import tw_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LOG_AW-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              bus_dir,
  output logic              dat_oe,
  input  logic              bank_match,
  output logic              bank_commit,
  output logic [1:0]        tgt_bank,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rx_byte,
  output logic              sh_start,
  output logic              sh_rx_mode,
  output logic [BYTE_W-1:0] sh_tx_byte
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  tw_state_e         state;
  logic              wr_q;
  logic [LOG_AW-1:0] addr_q;
  logic [BYTE_W-1:0] wdat_q;
  logic [BYTE_W-1:0] rd_q;
  logic [CW-1:0]     cnt;
  logic              dir_q, oe_q;
  logic              half_end;
  logic              accept;

  assign accept   = req_valid && (state == S_IDLE);
  assign half_end = (cnt == LAST);
  assign tgt_bank = bank_of(addr_q);

  // Byte launches, taken from state exits
  always_comb begin
    sh_start    = 1'b0;
    sh_rx_mode  = 1'b0;
    sh_tx_byte  = '0;
    bank_commit = 1'b0;
    case (state)
      S_BEGIN: if (half_end) begin
        sh_start = 1'b1;
        if (!bank_match) begin
          sh_tx_byte  = {6'd0, tgt_bank};
          bank_commit = 1'b1;
        end else begin
          sh_tx_byte = wr_q ? wdat_q : phys_of(addr_q);
        end
      end
      S_SEL_D: if (sh_done) begin
        sh_start   = 1'b1;
        sh_tx_byte = SEL_ADDR;
      end
      S_TGT0: if (sh_done && wr_q) begin
        sh_start   = 1'b1;
        sh_tx_byte = phys_of(addr_q);
      end
      S_END: if (half_end && !wr_q) begin
        sh_start   = 1'b1;
        sh_rx_mode = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rd_q   <= '0;
      cnt    <= '0;
      dir_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
      case (state)
        S_IDLE: if (accept) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          wdat_q <= remap_wdata(req_addr, req_wdata);
          rd_q   <= '0;
          cnt    <= '0;
          if (pwr_en) begin
            state <= S_BEGIN;
            dir_q <= 1'b1;
            oe_q  <= 1'b1;
          end else begin
            state <= S_DONE;
          end
        end
        S_BEGIN: if (half_end) state <= bank_match ? S_TGT0 : S_SEL_D;
        S_SEL_D: if (sh_done) state <= S_SEL_A;
        S_SEL_A: if (sh_done) begin
          state <= S_SEL_E;
          dir_q <= 1'b0;
          oe_q  <= 1'b0;
          cnt   <= '0;
        end
        S_SEL_E: if (half_end) begin
          state <= S_BEGIN;
          dir_q <= 1'b1;
          oe_q  <= 1'b1;
          cnt   <= '0;
        end
        S_TGT0: if (sh_done) begin
          if (wr_q) state <= S_TGT1;
          else begin
            state <= S_END;
            dir_q <= 1'b0;
            oe_q  <= 1'b0;
            cnt   <= '0;
          end
        end
        S_TGT1: if (sh_done) begin
          state <= S_END;
          dir_q <= 1'b0;
          oe_q  <= 1'b0;
          cnt   <= '0;
        end
        S_END: if (half_end) state <= wr_q ? S_DONE : S_RX;
        S_RX: if (sh_done) begin
          rd_q  <= sh_rx_byte;
          state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign rd_data   = rd_q;
  assign bus_dir   = dir_q;
  assign dat_oe    = oe_q;

  // R13: a taken request makes the block busy on the next cycle
  a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R13: completion strobe lasts a single cycle
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: the data driver is enabled only under a high direction line
  a_r3_oe_under_dir: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> bus_dir);

  // R4: receive phase keeps the data line released and direction low
  a_r4_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RX) |-> (!dat_oe && !bus_dir));

  // R12: unpowered request finishes next cycle with zero and no window
  a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !pwr_en) |=> (done && rd_data == '0 && !bus_dir));

  // R6: after a bank-select launch the tracker reports a match
  a_r6_commit_matches: assert property (@(posedge clk) disable iff (!rst_n)
    bank_commit |=> bank_match);

endmodule

// File: rtl/tw_bus_master.sv
module tw_bus_master #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_en,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [4:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       bus_dir,
  output logic       bus_clk,
  output logic       dat_out,
  output logic       dat_oe,
  input  logic       dat_in
);

  logic       bank_match, bank_commit;
  logic [1:0] tgt_bank;
  logic       sh_done, sh_start, sh_rx_mode;
  logic [7:0] sh_rx_byte, sh_tx_byte;

  tw_sequencer #(.HALF_CYC(HALF_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_en      (pwr_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .done        (done),
    .rd_data     (rd_data),
    .bus_dir     (bus_dir),
    .dat_oe      (dat_oe),
    .bank_match  (bank_match),
    .bank_commit (bank_commit),
    .tgt_bank    (tgt_bank),
    .sh_done     (sh_done),
    .sh_rx_byte  (sh_rx_byte),
    .sh_start    (sh_start),
    .sh_rx_mode  (sh_rx_mode),
    .sh_tx_byte  (sh_tx_byte)
  );

  tw_bank_tracker u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .tgt_bank (tgt_bank),
    .commit   (bank_commit),
    .match    (bank_match)
  );

  tw_byte_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .rx_mode (sh_rx_mode),
    .tx_byte (sh_tx_byte),
    .din     (dat_in),
    .done    (sh_done),
    .rx_byte (sh_rx_byte),
    .bus_clk (bus_clk),
    .dout    (dat_out)
  );

endmodule

// File: tb/tw_bus_master_tb.sv
module tw_bus_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_en = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       done;
  logic [7:0] rd_data;
  logic       bus_dir, bus_clk, dat_out, dat_oe;
  logic       dat_in = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_bus_master #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .bus_dir(bus_dir), .bus_clk(bus_clk), .dat_out(dat_out), .dat_oe(dat_oe),
    .dat_in(dat_in)
  );

  // ---------------- bus-side model ----------------
  logic [15:0] fr_bits [0:7];
  int          fr_len  [0:7];
  int          nfr = 0;
  logic [15:0] cur = '0;
  int          nb = 0;
  logic [7:0]  rd_model = '0;
  int          ridx = 0;
  int          edge_cnt = 0;

  always @(posedge bus_clk) begin
    if (bus_dir === 1'b1) begin
      if (nb < 16) cur[nb] = dat_out;
      nb++;
    end
  end

  always @(negedge bus_dir) begin
    if (nfr < 8) begin
      fr_bits[nfr] = cur;
      fr_len[nfr]  = nb;
    end
    nfr++;
    nb   = 0;
    cur  = '0;
    ridx = 0;
  end

  always @(negedge bus_clk) begin
    edge_cnt++;
    if (bus_dir === 1'b0) begin
      dat_in = rd_model[ridx % 8];
      ridx++;
    end
  end

  // ---------------- timing monitors (R1, R3) ----------------
  int  low_run = 0, low_bad = 0, low_seen = 0;
  int  gap = 0, gap_bad = 0, gap_seen = 0;
  bit  gapping = 0, dir_p = 0;
  int  oe_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_clk === 1'b0) low_run++;
      else if (low_run > 0) begin
        low_seen++;
        if (low_run != HALF) low_bad++;
        low_run = 0;
      end
      if (dat_oe === 1'b1 && bus_dir !== 1'b1) oe_bad++;
      if (bus_dir === 1'b1 && !dir_p) begin
        gap = 0; gapping = 1;
        if (dat_oe !== 1'b1) oe_bad++;
      end else if (gapping) begin
        if (bus_clk === 1'b0) begin
          gap_seen++;
          if (gap != HALF - 1) gap_bad++;
          gapping = 0;
        end else gap++;
      end
      dir_p = (bus_dir === 1'b1);
    end
  end

  // ---------------- reporting ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      summary();
    end
  end

  // ---------------- expected-value functions ----------------
  function automatic int bank_exp(input logic [4:0] a);
    return (a >= 5'h10) ? 2 : 1;
  endfunction

  function automatic logic [7:0] phys_exp(input logic [4:0] a);
    return (a >= 5'h10) ? 8'(a - 5'h10) : 8'(a);
  endfunction

  function automatic logic [7:0] wire_data_exp(input logic [4:0] a, input logic [7:0] d);
    int v;
    v = int'(d);
    if (a == 5'h03) return ~d;
    if (a == 5'h09) return (v < 64) ? 8'(255 - v) : 8'((191 - v) & 255);
    if (a == 5'h12) return {d[7:5], 1'b1, d[3:2], 2'b11};
    return d;
  endfunction

  int bank_model = 0;   // 0 = unknown after reset

  task automatic xact(input bit wr, input logic [4:0] a, input logic [7:0] d,
                      input bit pwr, input logic [7:0] rv, input string tag);
    int idx, eb, edges0;
    logic [15:0] ef;
    rd_model = rv;
    nfr = 0;
    edges0 = edge_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    pwr_en = pwr; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, {tag, " R13 busy"}, req_ready, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, {tag, " R13 pulse"}, done, 0);
    if (!pwr) begin
      chk(rd_data == 8'h00, {tag, " R12 rd zero"}, rd_data, 0);
      chk(nfr == 0 && edge_cnt == edges0, {tag, " R12 quiet"}, nfr, 0);
    end else begin
      idx = 0;
      eb = bank_exp(a);
      if (eb != bank_model) begin
        ef = {8'h01, 8'(eb)};
        chk(fr_len[0] == 16 && fr_bits[0] == ef, {tag, " R6 select window"}, fr_bits[0], ef);
        idx = 1;
        bank_model = eb;
      end
      if (wr) begin
        ef = {phys_exp(a), wire_data_exp(a, d)};
        chk(fr_len[idx] == 16 && fr_bits[idx] == ef, {tag, " R2 write window"}, fr_bits[idx], ef);
        chk(rd_data == 8'h00, {tag, " R13 write rd"}, rd_data, 0);
      end else begin
        chk(fr_len[idx] == 8 && fr_bits[idx][7:0] == phys_exp(a),
            {tag, " R4 address window"}, fr_bits[idx][7:0], phys_exp(a));
        chk(rd_data == rv, {tag, " R4 read data"}, rd_data, rv);
      end
      chk(nfr == idx + 1, {tag, " R6 window count"}, nfr, idx + 1);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0 || req_ready == 1'b1, "reset ready known", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !bus_dir && !dat_oe && bus_clk,
        "R13 reset idle state", {req_ready, done, bus_dir, dat_oe, bus_clk}, 5'b10001);

    // R12 before any powered access: no window, bank stays unknown
    xact(1'b0, 5'h05, 8'h00, 1'b0, 8'h77, "off-read");
    // R7: first powered access carries a select; R8 remap
    xact(1'b1, 5'h03, 8'h21, 1'b1, 8'h00, "R7 R8 first");
    xact(1'b1, 5'h03, 8'h00, 1'b1, 8'h00, "R8 zero");
    // R6: same bank, no select
    xact(1'b1, 5'h0A, 8'h5C, 1'b1, 8'h00, "R6 R11 same bank");
    // R9 boundaries
    xact(1'b1, 5'h09, 8'd10,  1'b1, 8'h00, "R9 low");
    xact(1'b1, 5'h09, 8'd63,  1'b1, 8'h00, "R9 63");
    xact(1'b1, 5'h09, 8'd64,  1'b1, 8'h00, "R9 64");
    xact(1'b1, 5'h09, 8'd191, 1'b1, 8'h00, "R9 191");
    xact(1'b1, 5'h09, 8'd250, 1'b1, 8'h00, "R9 wrap");
    // R5 R10: bank 2 with forced bits
    xact(1'b1, 5'h12, 8'h00, 1'b1, 8'h00, "R5 R10 zero");
    xact(1'b1, 5'h12, 8'hA4, 1'b1, 8'h00, "R10 mixed");
    // R4 reads both banks
    xact(1'b0, 5'h1D, 8'h00, 1'b1, 8'hA5, "R4 R5 read b2");
    xact(1'b0, 5'h00, 8'h00, 1'b1, 8'h01, "R4 read lsb");
    xact(1'b0, 5'h0E, 8'h00, 1'b1, 8'h80, "R4 read msb");
    // R12: unpowered request between banks leaves tracking alone
    xact(1'b1, 5'h15, 8'h33, 1'b0, 8'h00, "R12 off write");
    xact(1'b1, 5'h15, 8'h33, 1'b1, 8'h00, "R12 bank kept");

    for (int i = 0; i < 80; i++) begin
      logic [4:0] ra;
      logic [7:0] rd, rv;
      bit rw, rp;
      ra = 5'($urandom);
      rd = 8'($urandom);
      rv = 8'($urandom);
      rw = 1'($urandom);
      rp = ($urandom % 8) != 0;
      xact(rw, ra, rd, rp, rv, "R11 random");
    end

    chk(low_seen > 0 && low_bad == 0, "R1 clock low length", low_bad, 0);
    chk(gap_seen > 0 && gap_bad == 0, "R3 setup before first clock", gap_bad, 0);
    chk(oe_bad == 0, "R3 driver under direction", oe_bad, 0);
    summary();
  end

endmodule